// File: doc/BRIEF.md
# Debounced Eight-Input Serial Reader

This block sits on the device side of a serial link. It takes eight raw digital inputs, filters each one against contact bounce, and returns them on a four-wire serial port. A chip-select, a serial clock, a serial data input and a serial data output are all treated as asynchronous and sampled by the block clock. When chip-select falls, the block takes a snapshot of the filtered inputs. It then shifts that snapshot out, most significant bit first.

A frame-length input selects one of two frames:
- The short frame carries only the eight input bits.
- The long frame adds a status byte. That byte holds a 5-bit check code over the input bits, an over-temperature flag, and two supply-low indicators.

Temperature and supply sensing sit outside the block. They arrive here as plain flag inputs. Bits that arrive on the serial data input flow through the register behind the block's own frame, so several blocks can be chained on one chip-select.

The serial port has no valid/ready handshake and no back-pressure. The master sets the pace through the serial clock. Data moves only while chip-select is low. The serial clock must stay below one eighth of the block clock rate.

Top module: `din_serializer`

## Requirements
- R1: After reset, `sdo` is 0 and `fault` is 0, provided the flag inputs are held at their idle levels (overtemp 0, both supply-low inputs 1).
- R2: The filtered inputs and the flags are captured on the falling edge of `cs_n`. Input changes made after that edge do not alter the frame being shifted.
- R3: Status bits [7:3] hold a 5-bit check code over the captured input byte. The code uses the generator x^5+x^4+x^2+1, starts from zero, and processes bit 7 first. It equals the remainder of (byte × x^5) divided by the generator.
- R4: Status bit 2 is the supply-low alarm (0 = raised). Bit 1 is over-temperature (1 = raised). Bit 0 is the supply-low warning (0 = raised). Each bit carries the level of its input pin.
- R5: With `frame16` = 0, the frame is the input byte, bit 7 first. The bits received on `sdi` follow it, starting at the 9th serial clock.
- R6: With `frame16` = 1, the frame is the input byte followed by the status byte, each bit 7 first. The bits received on `sdi` follow it, starting at the 17th serial clock.
- R7: The first frame bit is on `sdo` before the first rising edge of `sclk`. Each later bit appears after a falling edge of `sclk`. `sdi` is sampled on the rising edge.
- R8: With `filt_sel` = 2'b00 the filter is off. An input change reaches the next captured frame within a few block clocks.
- R9: The value of `filt_sel` sets the filter time, with the low bit acting as the mid-range select:
  - 2'b10 gives SHORT_US.
  - 2'b01 gives MID_US.
  - 2'b11 gives LONG_US.
  Each time is scaled by CYC_PER_US block clocks. A changed input passes only after it has differed from the filtered value for that many consecutive clocks. A shorter pulse is discarded.
- R10: `fault` is 1 while over-temperature is high or the supply-low alarm is low. The supply-low warning alone does not raise it.
- R11: While `cs_n` is high, `sclk` edges do not move the register, and `sdo` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 8 | Raw digital inputs |
| filt_sel | input | 2 | Filter time select |
| frame16 | input | 1 | 1 = long frame with status byte |
| overtemp | input | 1 | Over-temperature flag, active high |
| uv_alarm_n | input | 1 | Supply-low alarm, active low |
| uv_warn_n | input | 1 | Supply-low warning, active low |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Chain data in |
| sdo | output | 1 | Serial data out |
| fault | output | 1 | Alarm summary, active high |

## Verification
Each filter setting is probed just before and just after its window closes. A filter with the wrong scale or a swapped select decode would hand the new value over too early or hold it too long. A pulse shorter than the window is also applied; a filter that does not restart its count would let that pulse through.

Input changes are made just after chip-select falls. A block that captures late would return the new value.

The chained bits are checked at exactly frame length. A register that is one bit too long or too short, or that fails to shrink in the short frame, puts them at the wrong slot.

Serial clock pulses are given while chip-select is high. A block that shifts on them loses its first bit.

// File: rtl/din_ser_pkg.sv
package din_ser_pkg;
  localparam int unsigned CHANS = 8;
  localparam int unsigned CRC_W = 5;
  localparam logic [CRC_W-1:0] CRC_POLY = 5'h15;

  typedef enum logic [1:0] {
    FILT_OFF   = 2'b00,
    FILT_MID   = 2'b01,
    FILT_SHORT = 2'b10,
    FILT_LONG  = 2'b11
  } filt_e;

  typedef struct packed {
    logic [CRC_W-1:0] code;
    logic             uv_alarm_n;
    logic             hot;
    logic             uv_warn_n;
  } status_t;

  function automatic logic [CRC_W-1:0] check_code(input logic [CHANS-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = CHANS - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/dser_sync.sv
module dser_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dser_debounce.sv
module dser_debounce #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic [CNT_W-1:0] limit,
  input  logic             raw,
  output logic             clean
);
  logic [CNT_W-1:0] cnt;
  logic             last_cnt;

  assign last_cnt = (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clean <= 1'b0;
    end else if (bypass) begin
      cnt   <= '0;
      clean <= raw;
    end else if (raw == clean) begin
      cnt   <= '0;
    end else if (last_cnt) begin
      cnt   <= '0;
      clean <= raw;
    end else begin
      cnt   <= cnt + CNT_W'(1);
    end
  end

  // R9: an agreeing input never moves the filtered value
  a_r9_hold_on_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && raw == clean) |=> $stable(clean));
  // R9: no hand-over before the window has run out
  a_r9_no_early_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && raw != clean && !last_cnt) |=> $stable(clean));
endmodule

// File: rtl/dser_frame.sv
module dser_frame
  import din_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_s,
  input  logic             sclk_s,
  input  logic             sdi_s,
  input  logic             long_frame,
  input  logic [CHANS-1:0] data,
  input  status_t          status,
  output logic             sdo,
  output logic             load,
  output logic             long_q,
  output logic [2*CHANS-1:0] frame_q
);
  localparam int unsigned FW = 2 * CHANS;

  logic [FW-1:0] sr;
  logic cs_q, sclk_q, sdi_hold, mode_q;
  logic sclk_rise, sclk_fall, active;

  assign load      = cs_q & ~cs_n_s;
  assign active    = ~cs_n_s;
  assign sclk_rise = ~sclk_q & sclk_s;
  assign sclk_fall = sclk_q & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      sdi_hold <= 1'b0;
      mode_q   <= 1'b0;
      sr       <= '0;
    end else begin
      cs_q   <= cs_n_s;
      sclk_q <= sclk_s;
      if (active && sclk_rise) sdi_hold <= sdi_s;
      if (load) begin
        mode_q <= long_frame;
        sr     <= long_frame ? {data, status} : {data, {CHANS{1'b0}}};
      end else if (active && sclk_fall) begin
        if (mode_q) sr <= {sr[FW-2:0], sdi_hold};
        else        sr[FW-1:CHANS] <= {sr[FW-2:CHANS], sdi_hold};
      end
    end
  end

  assign sdo     = sr[FW-1];
  assign long_q  = mode_q;
  assign frame_q = sr;

  // R11: idle chip-select keeps the register still
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && cs_q) |=> $stable(sr));
  // R3: an all-zero byte carries an all-zero check code
  a_r3_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (load && long_frame && data == '0) |=> (sr[CHANS-1:CHANS-CRC_W] == '0));
  // R5: the short frame leaves the low half cleared
  a_r5_low_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !long_frame) |=> (sr[CHANS-1:0] == '0));
endmodule

// File: rtl/din_serializer.sv
module din_serializer
  import din_ser_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 4,
  parameter int unsigned SHORT_US   = 25,
  parameter int unsigned MID_US     = 750,
  parameter int unsigned LONG_US    = 3000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] din,
  input  logic [1:0] filt_sel,
  input  logic       frame16,
  input  logic       overtemp,
  input  logic       uv_alarm_n,
  input  logic       uv_warn_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       fault
);
  localparam int unsigned SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int unsigned MID_CYC   = MID_US * CYC_PER_US;
  localparam int unsigned LONG_CYC  = LONG_US * CYC_PER_US;
  localparam int unsigned CNT_W     = $clog2(LONG_CYC + 1);
  localparam int unsigned CTL_W     = 9;
  localparam logic [CTL_W-1:0] CTL_IDLE = 9'b1_0_0_0_00_0_1_1;

  logic [CHANS-1:0] din_s, din_f;
  logic [CTL_W-1:0] ctl_s;
  logic cs_n_s, sclk_s, sdi_s, long_s, hot_s, uva_s, uvw_s;
  logic [1:0] filt_s;
  logic [CNT_W-1:0] limit;
  logic bypass, load, long_q;
  logic [2*CHANS-1:0] frame_q;
  status_t st;

  dser_sync #(.W(CHANS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s));

  dser_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, sdi, frame16, filt_sel, overtemp, uv_alarm_n, uv_warn_n}),
    .q(ctl_s));

  assign {cs_n_s, sclk_s, sdi_s, long_s, filt_s, hot_s, uva_s, uvw_s} = ctl_s;

  always_comb begin
    bypass = 1'b0;
    unique case (filt_e'(filt_s))
      FILT_SHORT: limit = CNT_W'(SHORT_CYC);
      FILT_MID:   limit = CNT_W'(MID_CYC);
      FILT_LONG:  limit = CNT_W'(LONG_CYC);
      default: begin
        limit  = CNT_W'(1);
        bypass = 1'b1;
      end
    endcase
  end

  for (genvar g = 0; g < CHANS; g++) begin : g_filt
    dser_debounce #(.CNT_W(CNT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .bypass(bypass), .limit(limit),
      .raw(din_s[g]), .clean(din_f[g]));
  end

  always_comb begin
    st.code       = check_code(din_f);
    st.uv_alarm_n = uva_s;
    st.hot        = hot_s;
    st.uv_warn_n  = uvw_s;
  end

  dser_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .long_frame(long_s), .data(din_f), .status(st), .sdo(sdo), .load(load),
    .long_q(long_q), .frame_q(frame_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= hot_s | ~uva_s;
  end

  // R10: the summary pin agrees with the flags just placed in a long frame
  a_r10_fault_vs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (load && long_s) |=> (long_q && fault == (frame_q[1] | ~frame_q[2])));
  // R6: the long frame holds the filtered byte in its top half
  a_r6_top_half: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (frame_q[2*CHANS-1:CHANS] == $past(din_f)));
endmodule

// File: tb/tb_din_serializer.sv
module tb_din_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int CPU = 1;
  localparam int N_SHORT = 25 * CPU;
  localparam int N_MID = 750 * CPU;
  localparam int N_LONG = 3000 * CPU;
  localparam int NV = 8;
  // {data, frame16, overtemp, uv_alarm_n, uv_warn_n}
  localparam logic [11:0] VECS [NV] = '{
    {8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h01, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'hA5, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'hFF, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h3C, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h80, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h5A, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'hC3, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] din = 0;
  logic [1:0] filt_sel = 0;
  logic frame16 = 0, overtemp = 0, uv_alarm_n = 1, uv_warn_n = 1;
  logic cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, fault;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  din_serializer #(.CYC_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .filt_sel(filt_sel), .frame16(frame16),
    .overtemp(overtemp), .uv_alarm_n(uv_alarm_n), .uv_warn_n(uv_warn_n),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .fault(fault));

  function automatic logic [4:0] ref_code(input logic [7:0] d);
    logic [12:0] r;
    r = {d, 5'b0};
    for (int i = 12; i >= 5; i--) if (r[i]) r[i-:6] = r[i-:6] ^ 6'b110101;
    return r[4:0];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_frame(input int nbits, input logic [7:0] spat, input bit late,
                           input logic [7:0] late_din, output logic [31:0] got);
    got = 0;
    cs_n = 0;
    repeat (HALF) @(posedge clk);
    if (late) din = late_din;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      got = {got[30:0], sdo};
      sdi = (k < 8) ? spat[7-k] : 1'b0;
      repeat (HALF) @(posedge clk);
      sclk = 1;
      repeat (HALF) @(posedge clk);
      sclk = 0;
      repeat (HALF) @(posedge clk);
    end
    cs_n = 1;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic read8(output logic [7:0] b);
    logic [31:0] g;
    frame16 = 0;
    repeat (4) @(posedge clk);
    run_frame(8, 8'h00, 0, 8'h00, g);
    b = g[7:0];
  endtask

  task automatic filt_test(input logic [1:0] sel, input int n, input string req);
    logic [7:0] b;
    filt_sel = 2'b00; din = 8'h0F; repeat (10) @(posedge clk);
    filt_sel = sel; repeat (10) @(posedge clk);
    @(posedge clk); din = 8'hF0;
    repeat (n - 20) @(posedge clk);
    read8(b); check({req, " before window"}, b, 8'h0F);
    repeat (n + 40) @(posedge clk);
    read8(b); check({req, " after window"}, b, 8'hF0);
    // short pulse is discarded
    @(posedge clk); din = 8'h0F;
    repeat (n / 2) @(posedge clk);
    din = 8'hF0;
    repeat (n + 40) @(posedge clk);
    read8(b); check({req, " short pulse dropped"}, b, 8'hF0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] g;
    logic [7:0] b;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 sdo after reset", sdo, 0);
    check("R1 fault after reset", fault, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check("R1 sdo idle", sdo, 0);
    check("R1 fault idle", fault, 0);

    // vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d, sp;
      logic m, ot, ua, uw;
      logic [31:0] exp;
      {d, m, ot, ua, uw} = VECS[v];
      sp = d ^ 8'h69;
      din = d; frame16 = m; overtemp = ot; uv_alarm_n = ua; uv_warn_n = uw;
      repeat (10) @(posedge clk);
      if (m) begin
        run_frame(24, sp, 0, 8'h00, g);
        exp = {8'h00, d, ref_code(d), ua, ot, uw, sp};
        check("R3 R4 R6 R7 long frame", g, exp);
      end else begin
        run_frame(16, sp, 0, 8'h00, g);
        check("R5 R7 short frame", g, {16'h0, d, sp});
      end
    end

    // R10 fault summary
    overtemp = 1; uv_alarm_n = 1; uv_warn_n = 1; repeat (6) @(negedge clk);
    check("R10 overtemp", fault, 1);
    overtemp = 0; uv_alarm_n = 0; repeat (6) @(negedge clk);
    check("R10 uv alarm", fault, 1);
    uv_alarm_n = 1; uv_warn_n = 0; repeat (6) @(negedge clk);
    check("R10 warn only", fault, 0);
    uv_warn_n = 1;

    // R2 capture at chip-select fall
    filt_sel = 2'b00; frame16 = 0; din = 8'h96; repeat (10) @(posedge clk);
    run_frame(8, 8'h00, 1, 8'h21, g);
    check("R2 late change ignored", g[7:0], 8'h96);
    read8(b); check("R2 next frame new value", b, 8'h21);

    // R8 filter off
    din = 8'h4E; repeat (6) @(posedge clk);
    read8(b); check("R8 filter off pass", b, 8'h4E);

    // R11 clocks ignored while deselected
    din = 8'h80; repeat (10) @(posedge clk);
    cs_n = 0; repeat (HALF) @(posedge clk);
    cs_n = 1; repeat (HALF) @(negedge clk);
    check("R11 first bit loaded", sdo, 1);
    for (int t = 0; t < 3; t++) begin
      sclk = 1; repeat (HALF) @(posedge clk);
      sclk = 0; repeat (HALF) @(posedge clk);
    end
    @(negedge clk);
    check("R11 sdo held while idle", sdo, 1);

    // R9 filter windows
    filt_test(2'b10, N_SHORT, "R9 short");
    filt_test(2'b01, N_MID, "R9 mid");
    filt_test(2'b11, N_LONG, "R9 long");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule